// File: doc/BRIEF.md
# DMA Channel Event and Completion-Interrupt Register Bank

This block holds the per-channel trigger and interrupt state for a 16-channel DMA controller. A one-cycle pulse on a channel's hardware event line latches a pending event. Software can also raise or drop events through two write-one registers, one that sets bits and one that clears them. A latched event becomes a start request towards the transfer engine only while that channel's enable bit is 1. When the engine accepts the request, the event bit drops by itself.

On the other side, the transfer engine reports each finished transfer together with that channel's completion-interrupt option. Completions that carry the option mark the channel in a pending register. One interrupt line is high whenever some pending channel also has its interrupt-enable bit set. Software clears pending bits by writing 1 to them.

Register access is a plain single-cycle bus. A write is taken on the clock edge while `reg_wr_i` is high. Read data follows `reg_addr_i` combinationally. Each channel n owns bit n of every register. Register bits above the channel count read as 0.

Top module: `dmaev_bank`

## Requirements
- R1: After reset every register reads 0, `xfer_req_o` is 0 and `irq_o` is low.
- R2: A 1 on `hw_evt_i[n]` at a clock edge sets bit n of the event register (address 0) after that edge, and the bit stays set until it is cleared.
- R3: `xfer_req_o[n]` is 1 exactly when event bit n and bit n of the event-enable register (address 1) are both 1. A disabled event stays latched and raises no request.
- R4: Writing to the event-clear register (address 3) clears the event bits where the write data is 1 and leaves the bits where it is 0.
- R5: Writing to the event-set register (address 2) sets the event bits where the write data is 1 and leaves the others. Addresses 2 and 3 read as 0.
- R6: When a hardware event and a clear write hit the same bit at the same edge, the bit ends up set.
- R7: `xfer_ack_i[n]` high while `xfer_req_o[n]` is high clears event bit n at that edge.
- R8: `xfer_done_i[n]` with `done_irq_opt_i[n]` high sets bit n of the pending register (address 4). A completion without the option leaves the pending register unchanged.
- R9: Writing 1 to a bit of address 4 clears that pending bit, and zeros have no effect. A completion on the same bit at the same edge keeps the bit set.
- R10: `irq_o` is high in the same cycle in which any pending bit has its matching bit set in the interrupt-enable register (address 5).
- R11: Addresses 1 and 5 read back what was written, limited to the channel bits. A write to address 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| hw_evt_i | input | 16 | Hardware event pulses, one per channel |
| xfer_req_o | output | 16 | Start requests to the transfer engine |
| xfer_ack_i | input | 16 | Request accepted by the transfer engine |
| xfer_done_i | input | 16 | Transfer finished, one per channel |
| done_irq_opt_i | input | 16 | Completion-interrupt option of the finishing channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with its defaults: 16 channels on a 32-bit data bus. The upper 16 data bits are therefore real bus bits with no register behind them, so full-width writes check that these bits read as 0. Each collision case is driven at one exact edge: a hardware event against a clear write, and a completion against a pending clear. This shows which side wins without relying on state the bit already held.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned REG_CNT = 6;

    typedef enum logic [ADDR_W-1:0] {
        RA_EVT     = 3'd0,
        RA_EVT_EN  = 3'd1,
        RA_EVT_SET = 3'd2,
        RA_EVT_CLR = 3'd3,
        RA_PEND    = 3'd4,
        RA_IRQ_EN  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/dmaev_w1_row.sv
module dmaev_w1_row #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d, q_q;

    // set has priority over clear, bit by bit
    always_comb begin
        for (int i = 0; i < W; i++) begin
            q_d[i] = set_i[i] | (q_q[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_d;
    end

    assign q_o = q_q;
endmodule

// File: rtl/dmaev_regdec.sv
module dmaev_regdec
    import dmaev_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_CH = 16
) (
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [NUM_CH-1:0]         evt_i,
    input  logic [NUM_CH-1:0]         evt_en_i,
    input  logic [NUM_CH-1:0]         pend_i,
    input  logic [NUM_CH-1:0]         irq_en_i,
    output logic [REG_CNT-1:0]        wsel_o,
    output logic [NUM_CH-1:0]         wbits_o,
    output logic [DATA_W-1:0]         rdata_o
);
    assign wbits_o = wdata_i[NUM_CH-1:0];

    generate
        if (DATA_W > NUM_CH) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_CH];
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < REG_CNT; k++) begin
            wsel_o[k] = wr_i && (addr_i == ADDR_W'(k));
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            RA_EVT:    rdata_o[NUM_CH-1:0] = evt_i;
            RA_EVT_EN: rdata_o[NUM_CH-1:0] = evt_en_i;
            RA_PEND:   rdata_o[NUM_CH-1:0] = pend_i;
            RA_IRQ_EN: rdata_o[NUM_CH-1:0] = irq_en_i;
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dmaev_irq_merge.sv
module dmaev_irq_merge #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    logic [W-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_hit
            assign hit[g] = pend_i[g] & en_i[g];
        end
    endgenerate

    assign irq_o = |hit;
endmodule

// File: rtl/dmaev_bank.sv
module dmaev_bank
    import dmaev_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [NUM_CH-1:0] hw_evt_i,
    output logic [NUM_CH-1:0] xfer_req_o,
    input  logic [NUM_CH-1:0] xfer_ack_i,
    input  logic [NUM_CH-1:0] xfer_done_i,
    input  logic [NUM_CH-1:0] done_irq_opt_i,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] evt_en;
        logic [NUM_CH-1:0] irq_en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [REG_CNT-1:0] wsel;
    logic [NUM_CH-1:0]  wbits;
    logic [NUM_CH-1:0]  evt_q, pend_q;
    logic [NUM_CH-1:0]  evt_set, evt_clr, pend_set, pend_clr;

    dmaev_regdec #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) i_regdec (
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .evt_i    (evt_q),
        .evt_en_i (ctl_q.evt_en),
        .pend_i   (pend_q),
        .irq_en_i (ctl_q.irq_en),
        .wsel_o   (wsel),
        .wbits_o  (wbits),
        .rdata_o  (reg_rdata_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        if (wsel[int'(RA_EVT_EN)]) ctl_d.evt_en = wbits;
        if (wsel[int'(RA_IRQ_EN)]) ctl_d.irq_en = wbits;

        evt_set  = hw_evt_i | (wsel[int'(RA_EVT_SET)] ? wbits : '0);
        evt_clr  = (wsel[int'(RA_EVT_CLR)] ? wbits : '0) | (xfer_ack_i & xfer_req_o);
        pend_set = xfer_done_i & done_irq_opt_i;
        pend_clr = wsel[int'(RA_PEND)] ? wbits : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    dmaev_w1_row #(.W(NUM_CH)) i_evt_row (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .q_o    (evt_q)
    );

    dmaev_w1_row #(.W(NUM_CH)) i_pend_row (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .q_o    (pend_q)
    );

    assign xfer_req_o = evt_q & ctl_q.evt_en;

    dmaev_irq_merge #(.W(NUM_CH)) i_irq (
        .pend_i (pend_q),
        .en_i   (ctl_q.irq_en),
        .irq_o  (irq_o)
    );

    // R10: interrupt only with something pending
    p_irq_has_pend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (pend_q != '0));

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chk
            p_hw_evt_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                hw_evt_i[g] |=> evt_q[g]);
            p_clr_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (reg_wr_i && reg_addr_i == RA_EVT_CLR && reg_wdata_i[g] && !evt_set[g])
                |=> !evt_q[g]);
            p_evt_beats_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (hw_evt_i[g] && reg_wr_i && reg_addr_i == RA_EVT_CLR) |=> evt_q[g]);
            p_ack_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (xfer_req_o[g] && xfer_ack_i[g] && !evt_set[g]) |=> !xfer_req_o[g]);
            p_done_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (xfer_done_i[g] && done_irq_opt_i[g]) |=> pend_q[g]);
        end
    endgenerate
endmodule

// File: tb/test_dmaev_bank.sv
module test_dmaev_bank;
    localparam int unsigned NCH = 16;
    localparam int unsigned DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] hw_evt = '0, ack = '0, done = '0, opt = '0;
    logic [NCH-1:0] req;
    logic           irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dmaev_bank #(.NUM_CH(NCH), .DATA_W(DW)) i_dmaev_bank (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hw_evt_i(hw_evt),
        .xfer_req_o(req), .xfer_ack_i(ack), .xfer_done_i(done),
        .done_irq_opt_i(opt), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int a = 0; a < 6; a++) begin
            reg_read(3'(a), v);
            check("R1 reg after reset", v, '0);
        end
        check("R1 req after reset", DW'(req), '0);
        check("R1 irq after reset", DW'(irq), '0);
    endtask

    task automatic t_hw_event();
        logic [DW-1:0] v;
        hw_evt = 16'h0008;
        @(negedge clk);
        hw_evt = '0;
        @(negedge clk);
        reg_read(3'd0, v);
        check("R2 event latched and held", v, 32'h0000_0008);
        check("R3 disabled event no request", DW'(req), '0);
        reg_write(3'd1, 32'h0000_0008);
        check("R3 enabled event requests", DW'(req), 32'h0000_0008);
    endtask

    task automatic t_ack();
        logic [DW-1:0] v;
        ack = 16'h0008;
        @(negedge clk);
        ack = '0;
        reg_read(3'd0, v);
        check("R7 ack clears event", v, '0);
        check("R7 request dropped", DW'(req), '0);
    endtask

    task automatic t_set_clr();
        logic [DW-1:0] v;
        reg_write(3'd2, 32'h0000_00F0);
        reg_read(3'd0, v);
        check("R5 set write", v, 32'h0000_00F0);
        reg_write(3'd2, 32'h0);
        reg_read(3'd0, v);
        check("R5 zero set no effect", v, 32'h0000_00F0);
        reg_read(3'd2, v);
        check("R5 set reg reads zero", v, '0);
        reg_read(3'd3, v);
        check("R5 clr reg reads zero", v, '0);
        reg_write(3'd3, 32'h0000_0030);
        reg_read(3'd0, v);
        check("R4 clear write", v, 32'h0000_00C0);
        reg_write(3'd3, 32'h0);
        reg_read(3'd0, v);
        check("R4 zero clear no effect", v, 32'h0000_00C0);
        reg_write(3'd3, 32'hFFFF_FFFF);
        reg_read(3'd0, v);
        check("R4 clear all", v, '0);
    endtask

    task automatic t_race();
        logic [DW-1:0] v;
        hw_evt = 16'h0020;
        reg_write(3'd3, 32'h0000_0020);
        hw_evt = '0;
        reg_read(3'd0, v);
        check("R6 event beats clear", v, 32'h0000_0020);
        reg_write(3'd3, 32'h0000_0020);
        reg_read(3'd0, v);
        check("R6 cleanup clear", v, '0);
    endtask

    task automatic t_pending();
        logic [DW-1:0] v;
        done = 16'h0004; opt = 16'h0004;
        @(negedge clk);
        done = 16'h0080; opt = '0;
        @(negedge clk);
        done = '0;
        reg_read(3'd4, v);
        check("R8 only option completions pend", v, 32'h0000_0004);
        check("R10 irq low while disabled", DW'(irq), '0);
        reg_write(3'd5, 32'h0000_0004);
        check("R10 irq high once enabled", DW'(irq), 32'h1);
        reg_write(3'd4, 32'h0);
        reg_read(3'd4, v);
        check("R9 zero write keeps pending", v, 32'h0000_0004);
        done = 16'h0004; opt = 16'h0004;
        reg_write(3'd4, 32'h0000_0004);
        done = '0; opt = '0;
        reg_read(3'd4, v);
        check("R9 completion beats clear", v, 32'h0000_0004);
        reg_write(3'd4, 32'h0000_0004);
        reg_read(3'd4, v);
        check("R9 write one clears", v, '0);
        check("R10 irq drops", DW'(irq), '0);
    endtask

    task automatic t_rw();
        logic [DW-1:0] v;
        reg_write(3'd1, 32'hFFFF_FFFF);
        reg_read(3'd1, v);
        check("R11 evt enable readback", v, 32'h0000_FFFF);
        reg_write(3'd5, 32'hA5A5_5A5A);
        reg_read(3'd5, v);
        check("R11 irq enable readback", v, 32'h0000_5A5A);
        reg_write(3'd0, 32'h0000_0001);
        reg_read(3'd0, v);
        check("R11 event reg not writable", v, '0);
        check("R11 no request from ignored write", DW'(req), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hw_event();
        t_ack();
        t_set_clr();
        t_race();
        t_pending();
        t_rw();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule